// File: doc/BRIEF.md
# Self-Sequenced Two-Bit Looping Counter

This block is the gate-level form of a program loop that adds one to a small unsigned variable forever. A one-cycle pause follows each addition. Control is a one-hot token that passes through three D flip-flops: a start stage, an update stage and a pause stage. The variable sits in a bank of toggle flip-flops. A ripple carry chain, enabled only while the update stage holds the token, decides which bits flip.

The block takes no data. It has a clock and an active-low asynchronous reset that stands in for power-up, when every flip-flop clears. It drives the variable on `count_o` in every cycle, so each value is visible for exactly two cycles. The width defaults to two bits and is set by `WIDTH`. Because there is no data input and the output is a free-running value, the block has no valid/ready handshake and no back-pressure.

Top module: `loop_incr_counter`

## Requirements
- R1: While `rst_n` is low, every flip-flop is clear and `count_o` is 0.
- R2: On the first rising edge after reset release, the start stage takes the token. The start stage is never taken again. From then on exactly one of the three stages is hot in every cycle, so `count_o` reads 0 in the first two cycles after that edge.
- R3: `count_o` advances by one only on an edge at which the update stage is hot. On every other edge it holds its value.
- R4: The update stage and the pause stage alternate, so no two updates happen on consecutive edges and each value is visible for exactly two consecutive cycles.
- R5: From the all-ones value, the next update wraps `count_o` to 0.
- R6: The loop never ends. Counting edges from reset release as k = 1, 2, ..., the value after edge k is ((k-1)/2) mod 2^WIDTH, so for the default width the sequence is 0,0,1,1,2,2,3,3 and then repeats.
- R7: On an update, bit i of the variable toggles exactly when every bit below i is 1. Bit 0 toggles on every update.
- R8: Any `WIDTH` of 1 or more gives the same behaviour modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by every flip-flop |
| rst_n | input | 1 | Active-low asynchronous clear (power-up) |
| count_o | output | WIDTH | Current value of the looping variable |

## Verification
The bench builds two copies of the block. One uses the default width of 2, which gives the 0,0,1,1,2,2,3,3 trace. The other uses a width of 3, where the carry has to ripple through two stages before the top bit toggles and the wrap happens at 7. Both copies run through several full periods and then through a reset issued mid-run. This shows that the start stage is taken exactly once after each release and that the trace starts again from 0.

// File: rtl/loop_ctr_pkg.sv
package loop_ctr_pkg;

  // One-hot control token: one bit per sequencing stage
  typedef struct packed {
    logic pause;
    logic update;
    logic start;
  } stage_t;

  localparam int unsigned STAGE_COUNT = 3;

endpackage

// File: rtl/lc_token_ring.sv
module lc_token_ring
  import loop_ctr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output stage_t stage_q
);

  stage_t stage_d;
  logic   idle;

  // No stage hot only happens right after the clear, so the start
  // stage fires once and the token then circulates update <-> pause.
  assign idle = ~(stage_q.start | stage_q.update | stage_q.pause);

  always_comb begin
    stage_d        = '0;
    stage_d.start  = idle;
    stage_d.update = stage_q.start | stage_q.pause;
    stage_d.pause  = stage_q.update;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

endmodule

// File: rtl/lc_carry_chain.sv
module lc_carry_chain #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             enable,
  input  logic [WIDTH-1:0] value,
  output logic [WIDTH-1:0] toggle
);

  logic [WIDTH:0] carry;

  assign carry[0] = enable;

  for (genvar i = 0; i < WIDTH; i++) begin : g_ripple
    assign toggle[i]  = carry[i];
    assign carry[i+1] = carry[i] & value[i];
  end

endmodule

// File: rtl/lc_tff_bank.sv
module lc_tff_bank #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] toggle,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_tff
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[i] <= 1'b0;
      else if (toggle[i]) q[i] <= ~q[i];
    end
  end

endmodule

// File: rtl/loop_incr_counter.sv
module loop_incr_counter
  import loop_ctr_pkg::*;
#(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] count_o
);

  stage_t           stage_q;
  logic [WIDTH-1:0] toggle_en;
  logic [WIDTH-1:0] var_q;

  lc_token_ring u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .stage_q (stage_q)
  );

  lc_carry_chain #(.WIDTH(WIDTH)) u_carry (
    .enable (stage_q.update),
    .value  (var_q),
    .toggle (toggle_en)
  );

  lc_tff_bank #(.WIDTH(WIDTH)) u_bits (
    .clk    (clk),
    .rst_n  (rst_n),
    .toggle (toggle_en),
    .q      (var_q)
  );

  assign count_o = var_q;

endmodule

// File: rtl/loop_incr_counter_chk.sv
module loop_incr_counter_chk #(
  parameter int unsigned WIDTH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] cnt,
  input logic             st_start,
  input logic             st_update,
  input logic             st_pause,
  input logic [WIDTH-1:0] tgl
);

  logic begun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begun <= 1'b0;
    else        begun <= 1'b1;
  end

  // R1: cleared state during reset
  always @(posedge clk) begin
    if (!rst_n) a_r1_clear: assert (cnt == '0 && !st_start && !st_update && !st_pause);
  end

  // R2: exactly one stage hot once started
  a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    begun |-> $countones({st_start, st_update, st_pause}) == 1);

  // R2: start stage never re-entered
  a_r2_start_once: assert property (@(posedge clk) disable iff (!rst_n)
    begun |=> !st_start);

  // R3: hold when not updating
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !st_update |=> $stable(cnt));

  // R3 R5: advance by one modulo 2^WIDTH on update
  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    st_update |=> cnt == WIDTH'($past(cnt) + 1'b1));

  // R4: no back-to-back updates
  a_r4_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    st_update |=> st_pause);

  // R6: pause returns the token to update
  a_r6_loop: assert property (@(posedge clk) disable iff (!rst_n)
    st_pause |=> st_update);

  // R7: bit 0 toggle request tracks the update stage
  a_r7_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
    tgl[0] == st_update);

endmodule

bind loop_incr_counter loop_incr_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt       (count_o),
  .st_start  (stage_q.start),
  .st_update (stage_q.update),
  .st_pause  (stage_q.pause),
  .tgl       (toggle_en)
);

// File: tb/loop_incr_counter_test.sv
module loop_incr_counter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cnt2;
  logic [2:0] cnt3;

  int checks = 0;
  int errors = 0;
  int k = 0;          // edges since reset release
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  loop_incr_counter #(.WIDTH(2)) uut    (.clk(clk), .rst_n(rst_n), .count_o(cnt2));
  loop_incr_counter #(.WIDTH(3)) uut_w3 (.clk(clk), .rst_n(rst_n), .count_o(cnt3));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s k=%0d actual=%0d expected=%0d", tag, k, act, exp);
    end
  endtask

  function automatic int model(input int edges, input int modv);
    if (edges == 0) return 0;
    return ((edges - 1) / 2) % modv;
  endfunction

  int prev2 = 0;

  task automatic step();
    string tag;
    int e2;
    @(posedge clk);
    k++;
    @(negedge clk);
    e2 = model(k, 4);
    if (k <= 2)                      tag = "R2";
    else if (k > 8)                  tag = "R6";
    else if (e2 == 0)                tag = "R5";
    else                             tag = "R3 R4";
    check(tag, int'(cnt2), e2);
    check("R8", int'(cnt3), model(k, 8));
    // R7: the set of bits that flipped is the ripple pattern of an increment
    if (int'(cnt2) != prev2)
      check("R7", int'(cnt2) ^ prev2, prev2 ^ ((prev2 + 1) % 4));
    prev2 = int'(cnt2);
  endtask

  task automatic hold_reset(input int cycles);
    rst_n = 1'b0;
    k = 0;
    prev2 = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check("R1", int'(cnt2), 0);
      check("R1", int'(cnt3), 0);
    end
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    hold_reset(3);
    for (int i = 0; i < 40; i++) step();
    @(negedge clk);
    hold_reset(2);   // mid-run reset: trace must restart from 0
    for (int i = 0; i < 40; i++) step();
    finish_run();
  end

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule